// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A shift register keeps the outcomes of the most recent branches. That history is XORed with a slice of the branch address to select one entry in a table of two-bit saturating counters. The upper bit of the selected counter is the guess. The fetch side presents a branch address and gets back, within the same cycle, the guess and the table entry that produced it. The fetch side keeps that entry number with the branch.

When the branch resolves, the back end returns the stored entry number and the real outcome. The block then trains that counter and shifts the outcome into the history. A restore input lets the back end overwrite the history after a misprediction. A flush input, used on a context switch, puts every counter and the history back to their reset values.

Top module: `gshare_dir_pred`

## Requirements
- R1: A valid update shifts the history left by one and places the real outcome in bit 0 (1 = taken). In a cycle with no update, restore or flush, the history keeps its value.
- R2: `pred_idx` equals the history XOR `pred_pc[9:2]` (with default parameters). All other address bits have no effect on it.
- R3: `pred_taken` is the upper bit of the selected counter. Values 0 and 1 predict not taken; values 2 and 3 predict taken.
- R4: An update with outcome taken adds one to the counter at `upd_idx`, stopping at 3. An update with outcome not taken subtracts one, stopping at 0.
- R5: After reset, every counter holds 2 (weakly taken) and the history is zero.
- R6: While `flush` is high, every counter returns to 2 and the history to zero at the next edge. An update or restore in the same cycle has no effect.
- R7: When a prediction and an update select the same entry in the same cycle, the prediction reflects the counter value before the update.
- R8: A restore loads `hist_restore_val` into the history. It overrides the shift of an update in the same cycle, but that update still trains its counter.
- R9: An update trains only the counter named by `upd_idx`, whatever the current history. A counter at 3 (or at 0) keeps its prediction after one contrary outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous return of all state to reset values |
| pred_pc | input | 32 | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_idx | output | 8 | Table entry used for the prediction |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_idx | input | 8 | Table entry recorded at prediction time |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| hist_restore | input | 1 | Load the history from `hist_restore_val` |
| hist_restore_val | input | 8 | History value to restore |

## Verification
If a counter is trained wrongly, the effect shows on `pred_taken` the first time the matching entry is read after the bad edge. For a counter that has not crossed its midpoint, the effect only shows after later training moves it across. A history fault changes `pred_idx` for every address in the very next cycle, so probing with an address whose hashed bits are zero exposes the history directly. A fault in the flush or restore priority therefore appears one cycle after the event.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'b10;
  localparam ctr_t CTR_MAX  = 2'b11;
  localparam ctr_t CTR_MIN  = 2'b00;

  // Saturating step of a hysteresis counter.
  function automatic ctr_t ctr_train(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else       nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
    return nxt;
  endfunction

  // Direction encoded by a counter.
  function automatic logic ctr_dir(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/gshare_hist.sv
module gshare_hist #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              shift_en,
  input  logic              shift_bit,
  input  logic              load_en,
  input  logic [HIST_W-1:0] load_val,
  output logic [HIST_W-1:0] hist_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (flush)    hist_q <= '0;
    else if (load_en)  hist_q <= load_val;
    else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_bit};
  end

endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
  import gshare_pkg::*;
#(
  parameter int IDX_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [IDX_W-1:0]       rd_idx,
  output ctr_t                   rd_ctr,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic                   wr_taken,
  output logic [DEPTH-1:0][1:0]  tbl_q
);

  ctr_t wr_next;
  assign wr_next = ctr_train(tbl_q[wr_idx], wr_taken);

  // Read returns the registered value: a same-cycle write is not forwarded.
  assign rd_ctr = tbl_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) tbl_q[e] <= CTR_INIT;
    end else if (flush) begin
      for (int e = 0; e < DEPTH; e++) tbl_q[e] <= CTR_INIT;
    end else if (wr_en) begin
      tbl_q[wr_idx] <= wr_next;
    end
  end

endmodule

// File: rtl/gshare_dir_pred.sv
module gshare_dir_pred
  import gshare_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST_W = 8,
  parameter int PC_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_idx,
  input  logic              upd_valid,
  input  logic [HIST_W-1:0] upd_idx,
  input  logic              upd_taken,
  input  logic              hist_restore,
  input  logic [HIST_W-1:0] hist_restore_val
);

  localparam int DEPTH = 1 << HIST_W;

  logic [HIST_W-1:0]       ghr_q;
  logic [HIST_W-1:0]       pc_hash_bits;
  logic [DEPTH-1:0][1:0]   tbl_q;
  ctr_t                    sel_ctr;

  // Named events for the checker.
  logic ev_train;
  logic ev_restore;
  logic ev_shift;

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pred_pc[PC_W-1:PC_LSB+HIST_W], pred_pc[PC_LSB-1:0]};

  assign ev_train   = upd_valid & ~flush;
  assign ev_restore = hist_restore & ~flush;
  assign ev_shift   = ev_train & ~hist_restore;

  assign pc_hash_bits = pred_pc[PC_LSB +: HIST_W];
  assign pred_idx     = ghr_q ^ pc_hash_bits;
  assign pred_taken   = ctr_dir(sel_ctr);

  gshare_hist #(.HIST_W(HIST_W)) hist_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .shift_en (upd_valid),
    .shift_bit(upd_taken),
    .load_en  (hist_restore),
    .load_val (hist_restore_val),
    .hist_q   (ghr_q)
  );

  gshare_pht #(.IDX_W(HIST_W)) pht_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .rd_idx  (pred_idx),
    .rd_ctr  (sel_ctr),
    .wr_en   (upd_valid),
    .wr_idx  (upd_idx),
    .wr_taken(upd_taken),
    .tbl_q   (tbl_q)
  );

endmodule

// File: rtl/gshare_dir_pred_chk.sv
module gshare_dir_pred_chk #(
  parameter int HIST_W = 8,
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  localparam int DEPTH = 1 << HIST_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush,
  input logic [PC_W-1:0]       pred_pc,
  input logic                  pred_taken,
  input logic [HIST_W-1:0]     pred_idx,
  input logic [HIST_W-1:0]     upd_idx,
  input logic                  upd_taken,
  input logic [HIST_W-1:0]     hist_restore_val,
  input logic [HIST_W-1:0]     ghr_q,
  input logic [DEPTH-1:0][1:0] tbl_q,
  input logic                  ev_train,
  input logic                  ev_restore,
  input logic                  ev_shift
);

  logic [HIST_W-1:0] p_idx;
  logic [1:0]        cur_old;
  logic [1:0]        cur_at_pidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) p_idx <= '0;
    else        p_idx <= upd_idx;
  end

  assign cur_old     = tbl_q[upd_idx];
  assign cur_at_pidx = tbl_q[p_idx];

  p_hist_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_shift |=> ghr_q == {$past(ghr_q[HIST_W-2:0]), $past(upd_taken)});

  p_hist_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_train && !ev_restore && !flush) |=> $stable(ghr_q));

  p_idx_hash_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pred_idx == (ghr_q ^ pred_pc[PC_LSB +: HIST_W]));

  p_pred_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken == tbl_q[pred_idx][1]);

  p_ctr_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_train && upd_taken && cur_old != 2'd3) |=> cur_at_pidx == $past(cur_old) + 2'd1);

  p_ctr_sat_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_train && upd_taken && cur_old == 2'd3) |=> cur_at_pidx == 2'd3);

  p_ctr_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_train && !upd_taken && cur_old != 2'd0) |=> cur_at_pidx == $past(cur_old) - 2'd1);

  p_ctr_sat_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_train && !upd_taken && cur_old == 2'd0) |=> cur_at_pidx == 2'd0);

  p_flush_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ghr_q == '0) && (tbl_q[0] == 2'b10) && (tbl_q[DEPTH-1] == 2'b10));

  p_restore_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_restore |=> ghr_q == $past(hist_restore_val));

endmodule

bind gshare_dir_pred gshare_dir_pred_chk #(
  .HIST_W(HIST_W), .PC_W(PC_W), .PC_LSB(PC_LSB)
) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .flush           (flush),
  .pred_pc         (pred_pc),
  .pred_taken      (pred_taken),
  .pred_idx        (pred_idx),
  .upd_idx         (upd_idx),
  .upd_taken       (upd_taken),
  .hist_restore_val(hist_restore_val),
  .ghr_q           (ghr_q),
  .tbl_q           (tbl_q),
  .ev_train        (ev_train),
  .ev_restore      (ev_restore),
  .ev_shift        (ev_shift)
);

// File: tb/gshare_dir_pred_tb_top.sv
`timescale 1ns/1ps
module gshare_dir_pred_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        pred_taken;
  logic [7:0]  pred_idx;
  logic        upd_valid = 1'b0;
  logic [7:0]  upd_idx = '0;
  logic        upd_taken = 1'b0;
  logic        hist_restore = 1'b0;
  logic [7:0]  hist_restore_val = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] m_ghr;
  logic [1:0] m_ctr [256];

  always #2 clk = ~clk;

  gshare_dir_pred dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_idx(pred_idx), .upd_valid(upd_valid),
    .upd_idx(upd_idx), .upd_taken(upd_taken), .hist_restore(hist_restore),
    .hist_restore_val(hist_restore_val)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ghr = '0;
    for (int i = 0; i < 256; i++) m_ctr[i] = 2'b10;
  endtask

  // One clock with the given controls; bench model advances independently.
  task automatic cyc(input logic uv, input logic [7:0] ui, input logic ut,
                     input logic rv, input logic [7:0] rval, input logic fl);
    @(negedge clk);
    upd_valid = uv; upd_idx = ui; upd_taken = ut;
    hist_restore = rv; hist_restore_val = rval; flush = fl;
    @(posedge clk);
    if (fl) model_reset();
    else begin
      if (uv) begin
        if (ut && m_ctr[ui] != 2'd3) m_ctr[ui] = m_ctr[ui] + 2'd1;
        if (!ut && m_ctr[ui] != 2'd0) m_ctr[ui] = m_ctr[ui] - 2'd1;
      end
      if (rv) m_ghr = rval;
      else if (uv) m_ghr = {m_ghr[6:0], ut};
    end
    #1;
    upd_valid = 1'b0; hist_restore = 1'b0; flush = 1'b0;
  endtask

  // Read the counter at entry idx through the predict port.
  task automatic peek(input logic [7:0] idx, input logic exp_tk, input string tag);
    @(negedge clk);
    pred_pc = {22'h0, idx ^ m_ghr, 2'b00};
    #1;
    chk({tag, " idx"}, {24'h0, pred_idx}, {24'h0, idx});
    chk({tag, " dir"}, {31'h0, pred_taken}, {31'h0, exp_tk});
  endtask

  task automatic t_reset();
    model_reset();
    @(negedge clk); pred_pc = 32'h0; #1;
    chk("R5 history zero after reset", {24'h0, pred_idx}, 32'h0);
    peek(8'h00, 1'b1, "R5 init counter 00");
    peek(8'h55, 1'b1, "R5 init counter 55");
    peek(8'hFF, 1'b1, "R5 init counter ff");
  endtask

  task automatic t_hash();
    cyc(1, 8'h10, 1, 0, 8'h0, 0);
    cyc(1, 8'h10, 0, 0, 8'h0, 0);
    cyc(1, 8'h10, 1, 0, 8'h0, 0);
    cyc(1, 8'h10, 1, 0, 8'h0, 0);
    @(negedge clk); pred_pc = 32'h0; #1;
    chk("R1 history after T,N,T,T", {24'h0, pred_idx}, 32'h0B);
    pred_pc = 32'hABCD_E3FF; #1;
    chk("R2 hash ignores high and low pc bits", {24'h0, pred_idx}, {24'h0, 8'h0B ^ 8'hFF});
    pred_pc = 32'h0000_0150; #1;
    chk("R2 hash of pc[9:2]=54", {24'h0, pred_idx}, {24'h0, 8'h0B ^ 8'h54});
    repeat (3) cyc(0, 8'h0, 0, 0, 8'h0, 0);
    @(negedge clk); pred_pc = 32'h0; #1;
    chk("R1 history holds when idle", {24'h0, pred_idx}, 32'h0B);
  endtask

  task automatic t_counter();
    logic ut_seq [9] = '{0, 0, 0, 1, 1, 1, 1, 0, 0};
    logic ex_seq [9] = '{0, 0, 0, 0, 1, 1, 1, 1, 0};
    for (int k = 0; k < 9; k++) begin
      cyc(1, 8'h40, ut_seq[k], 0, 8'h0, 0);
      peek(8'h40, ex_seq[k], $sformatf("R4 R3 step %0d", k));
    end
    peek(8'h41, 1'b1, "R9 neighbour untouched");
    cyc(1, 8'h41, 1, 0, 8'h0, 0);
    cyc(1, 8'h41, 0, 0, 8'h0, 0);
    peek(8'h41, 1'b1, "R9 strong taken survives one not-taken");
    chk("R4 model agrees on 40", {30'h0, m_ctr[8'h40]}, 32'h1);
  endtask

  task automatic t_same_cycle();
    cyc(1, 8'h80, 0, 0, 8'h0, 0);
    @(negedge clk);
    pred_pc = {22'h0, 8'h80 ^ m_ghr, 2'b00};
    upd_valid = 1'b1; upd_idx = 8'h80; upd_taken = 1'b1;
    #1;
    chk("R7 same-cycle prediction sees old value", {31'h0, pred_taken}, 32'h0);
    @(posedge clk);
    m_ctr[8'h80] = 2'b10; m_ghr = {m_ghr[6:0], 1'b1};
    #1 upd_valid = 1'b0;
    peek(8'h80, 1'b1, "R7 update lands after edge");
  endtask

  task automatic t_restore();
    cyc(1, 8'h20, 0, 1, 8'hA5, 0);
    @(negedge clk); pred_pc = 32'h0; #1;
    chk("R8 restore overrides shift", {24'h0, pred_idx}, 32'hA5);
    peek(8'h20, 1'b0, "R8 counter still trained");
    cyc(0, 8'h0, 0, 1, 8'h3C, 0);
    @(negedge clk); pred_pc = 32'h0; #1;
    chk("R8 restore alone", {24'h0, pred_idx}, 32'h3C);
  endtask

  task automatic t_flush();
    cyc(1, 8'h50, 0, 1, 8'h77, 1);
    @(negedge clk); pred_pc = 32'h0; #1;
    chk("R6 history cleared by flush", {24'h0, pred_idx}, 32'h0);
    peek(8'h40, 1'b1, "R6 trained entry back to init");
    peek(8'h20, 1'b1, "R6 entry 20 back to init");
    peek(8'h50, 1'b1, "R6 same-cycle update ignored");
    cyc(1, 8'h50, 0, 0, 8'h0, 0);
    peek(8'h50, 1'b0, "R6 init is weakly taken");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_hash();
    t_counter();
    t_same_cycle();
    t_restore();
    t_flush();
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule